// File: doc/BRIEF.md
# Windowed Watchdog Timer with Power-of-Two Timescale

This block is a watchdog timer that a host drives through a one-beat register write port. Each write carries a 3-bit timescale code in bits [2:0] and a kick bit in bit 7. A nonzero code arms the timer with a timeout of `BASE_TICKS × 2^code` periods of a millisecond tick enable. A zero code disarms it at once. A kick restarts the count. When the count runs out without a kick, the block emits a one-cycle expiry pulse and returns to the disarmed state.

The timer is windowed. A kick that comes fewer than `MIN_WIN_TICKS` ticks after arming or after the last accepted kick is treated as a fault. It sets a sticky error flag and, with the default `EARLY_EXPIRE = 1`, it also forces expiry. Arming is guarded as well: a nonzero code is accepted only after the block has been disarmed for at least `MIN_OFF_US` periods of a separate microsecond tick enable. This gap is counted from reset or from the last time the block was disarmed.

Defaults assume a 1.024 ms tick, so code 1 gives about 2 s, code 7 about 131 s, the kick window about 256 ms and the disarm gap 150 µs. All of these are parameters, so a bench can run them at an accelerated rate.

Top module: `wdt_windowed`

## Requirements
- R1: After reset the block is disarmed: `armed_o`=0, `scale_o`=0, `early_err_o`=0 and `expire_o`=0.
- R2: A write whose bits [2:0] are 0 disarms the block. From the next cycle `armed_o`=0 and `scale_o`=0, whatever bit 7 holds.
- R3: A write with a nonzero code arms the block, and `scale_o` then shows that code, only if the block is disarmed and has seen at least `MIN_OFF_US` microsecond ticks since reset or since it was last disarmed. An earlier write of this kind is rejected and the block stays disarmed.
- R4: A nonzero code written while the block is armed leaves `scale_o` and the running count unchanged.
- R5: Without a kick, the block expires on the `BASE_TICKS × 2^code`-th millisecond tick after arming or after the last accepted kick. `expire_o` is high for exactly the following cycle, in which `armed_o`=0 and `scale_o`=0.
- R6: A kick is a write with bit 7 = 1 when the previous write had bit 7 = 0 (or there has been no write since reset). A write that keeps bit 7 at 1 is not a kick.
- R7: A kick that comes at least `MIN_WIN_TICKS` ticks after arming or after the last accepted kick is accepted and restarts the timeout count from zero.
- R8: A kick that comes before `MIN_WIN_TICKS` ticks have elapsed sets `early_err_o`. With `EARLY_EXPIRE`=1 it also produces the expiry pulse and disarms the block. `early_err_o` stays set until reset.
- R9: A kick while the block is disarmed has no effect and does not set `early_err_o`.
- R10: An accepted kick in the same cycle as the final timeout tick wins: there is no expiry and the count restarts.
- R11: A write with code 0 and bit 7 set disarms the block without treating the kick as early: no error, no expiry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | Millisecond-scale tick enable for the timeout and the kick window |
| us_tick | input | 1 | Microsecond tick enable for the disarm gap |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: [2:0] timescale code, [7] kick bit |
| scale_o | output | 3 | Active timescale code, 0 when disarmed |
| armed_o | output | 1 | Timer armed |
| early_err_o | output | 1 | Sticky early-kick error |
| expire_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The collision that matters is a kick landing in the same cycle as the millisecond tick that would complete the timeout. There are two outcomes. If the kick falls outside the window, the kick must win: there is no pulse and the count restarts. If the kick falls inside the window, the early fault wins. A directed case sets the count one tick short of the timeout and then writes the kick together with that tick, and the bench judges the result from `expire_o` and `armed_o` on the next cycle. Random writes and ticks at two write densities then produce further collisions of this kind, along with disarm-plus-kick writes. These are checked every cycle against a reference model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SCALE_W  = 3;
  localparam int KICK_POS = 7;
  localparam int DATA_W   = 8;
  localparam int MAX_CODE = (1 << SCALE_W) - 1;

  typedef logic [SCALE_W-1:0] scale_t;

  // decoded view of one host write
  typedef struct packed {
    logic off_req;   // code 0 written
    logic arm_req;   // nonzero code written
    logic kick_bit;  // bit 7 value
  } wr_cmd_t;
endpackage

// File: rtl/wdt_kick_edge.sv
module wdt_kick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic kick_bit,
  output logic kick_pulse
);
  logic last_q, last_d;

  always_comb begin
    last_d = last_q;
    if (wr_en) last_d = kick_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  assign kick_pulse = wr_en & kick_bit & ~last_q;
endmodule

// File: rtl/wdt_off_timer.sv
module wdt_off_timer #(
  parameter int MIN_OFF_US = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic us_tick,
  output logic gap_done
);
  localparam int OW = $clog2(MIN_OFF_US + 1);
  localparam logic [OW-1:0] LIMIT = OW'(MIN_OFF_US);

  logic [OW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (us_tick && cnt_q != LIMIT) cnt_d = cnt_q + OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign gap_done = (cnt_q == LIMIT);
endmodule

// File: rtl/wdt_elapsed.sv
module wdt_elapsed
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS    = 1000,
  parameter int MIN_WIN_TICKS = 250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   restart,
  input  logic   ms_tick,
  input  scale_t scale,
  output logic   last_tick,
  output logic   in_window
);
  localparam int CW = $clog2((BASE_TICKS << MAX_CODE) + 1);
  localparam logic [CW-1:0] BASE_C = CW'(BASE_TICKS);
  localparam logic [CW-1:0] WIN_C  = CW'(MIN_WIN_TICKS);

  logic [CW-1:0] el_q, el_d, limit;

  assign limit     = BASE_C << scale;
  assign last_tick = run & ms_tick & (el_q == limit - CW'(1));
  assign in_window = (el_q < WIN_C);

  always_comb begin
    el_d = el_q;
    if (!run || restart)         el_d = '0;
    else if (ms_tick && !last_tick) el_d = el_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) el_q <= '0;
    else        el_q <= el_d;
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS    = 1000,
  parameter int MIN_WIN_TICKS = 250,
  parameter int MIN_OFF_US    = 150,
  parameter bit EARLY_EXPIRE  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  input  logic               us_tick,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [SCALE_W-1:0] scale_o,
  output logic               armed_o,
  output logic               early_err_o,
  output logic               expire_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  wr_cmd_t cmd;
  scale_t  scale_q, scale_d;
  logic    armed_q, armed_d, err_q, err_d, exp_q, exp_d;
  logic    kick_pulse, gap_done, last_tick, in_window;
  logic    kick_v, early, good_kick, trip, arm_ok, unused_bits;

  assign unused_bits  = ^wr_data[KICK_POS-1:SCALE_W];
  assign cmd.off_req  = wr_en & (wr_data[SCALE_W-1:0] == '0);
  assign cmd.arm_req  = wr_en & (wr_data[SCALE_W-1:0] != '0);
  assign cmd.kick_bit = wr_data[KICK_POS];

  wdt_kick_edge u_kick (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en),
    .kick_bit(cmd.kick_bit), .kick_pulse(kick_pulse)
  );

  wdt_off_timer #(.MIN_OFF_US(MIN_OFF_US)) u_gap (
    .clk(clk), .rst_n(rst_i_n), .clr(armed_q),
    .us_tick(us_tick), .gap_done(gap_done)
  );

  wdt_elapsed #(.BASE_TICKS(BASE_TICKS), .MIN_WIN_TICKS(MIN_WIN_TICKS)) u_el (
    .clk(clk), .rst_n(rst_i_n), .run(armed_q), .restart(good_kick),
    .ms_tick(ms_tick), .scale(scale_q),
    .last_tick(last_tick), .in_window(in_window)
  );

  always_comb begin
    arm_ok    = cmd.arm_req & ~armed_q & gap_done;
    kick_v    = kick_pulse & armed_q & ~cmd.off_req;
    early     = kick_v & in_window;
    good_kick = kick_v & ~in_window;
    trip      = armed_q & ~cmd.off_req &
                ((last_tick & ~good_kick) | (early & EARLY_EXPIRE));

    armed_d = armed_q;
    scale_d = scale_q;
    if (cmd.off_req || trip) begin
      armed_d = 1'b0;
      scale_d = '0;
    end else if (arm_ok) begin
      armed_d = 1'b1;
      scale_d = wr_data[SCALE_W-1:0];
    end
    err_d = err_q | early;
    exp_d = trip;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      armed_q <= 1'b0;
      scale_q <= '0;
      err_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      scale_q <= scale_d;
      err_q   <= err_d;
      exp_q   <= exp_d;
    end
  end

  assign scale_o     = scale_q;
  assign armed_o     = armed_q;
  assign early_err_o = err_q;
  assign expire_o    = exp_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [2:0] scale_o,
  input logic       armed_o,
  input logic       early_err_o,
  input logic       expire_o
);
  // R2
  off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] == 3'd0) |=> (!armed_o && scale_o == 3'd0));

  // R3
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(wr_en) && $past(wr_data[2:0]) == scale_o));

  // R4
  armed_rescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && wr_en && wr_data[2:0] != 3'd0) |=>
      (scale_o == $past(scale_o) || scale_o == 3'd0));

  // R5
  expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R5
  expire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (!armed_o && scale_o == 3'd0));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_err_o |=> early_err_o);

  // R9
  idle_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !early_err_o) |=> !early_err_o);

  // R3
  armed_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o == (scale_o != 3'd0));
endmodule

bind wdt_windowed wdt_checker u_wdt_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .scale_o(scale_o), .armed_o(armed_o),
  .early_err_o(early_err_o), .expire_o(expire_o)
);

// File: tb/tb_wdt_windowed.sv
module tb_wdt_windowed;
  localparam int BASE = 4;
  localparam int WIN  = 3;
  localparam int OFF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0, us_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] scale_o;
  logic       armed_o, early_err_o, expire_o;

  always #5 clk = ~clk;

  wdt_windowed #(.BASE_TICKS(BASE), .MIN_WIN_TICKS(WIN),
                 .MIN_OFF_US(OFF), .EARLY_EXPIRE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .us_tick(us_tick),
    .wr_en(wr_en), .wr_data(wr_data), .scale_o(scale_o),
    .armed_o(armed_o), .early_err_o(early_err_o), .expire_o(expire_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_scale, m_el, m_off;
  bit m_armed, m_err, m_exp, m_last;

  function automatic int timeout_of(int code);
    return BASE * (1 << code);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int  off0;
    bit  arm0, kedge, offw;
    if (!rst_n) begin
      m_scale = 0; m_el = 0; m_off = 0;
      m_armed = 0; m_err = 0; m_exp = 0; m_last = 0;
    end else begin
      off0  = m_off;
      arm0  = m_armed;
      kedge = wr_en && wr_data[7] && !m_last;
      if (wr_en) m_last = wr_data[7];
      offw  = wr_en && (wr_data[2:0] == 3'd0);
      m_exp = 0;
      if (!arm0) begin
        if (us_tick && m_off < OFF) m_off++;
      end else m_off = 0;
      if (arm0) begin
        if (offw) begin
          m_armed = 0; m_scale = 0;                 // R2, R11
        end else if (kedge && m_el < WIN) begin
          m_err = 1; m_exp = 1; m_armed = 0; m_scale = 0;  // R8
        end else if (kedge) begin
          m_el = 0;                                 // R7, R10
        end else if (ms_tick) begin
          m_el++;
          if (m_el == timeout_of(m_scale)) begin    // R5
            m_exp = 1; m_armed = 0; m_scale = 0;
          end
        end
      end else if (wr_en && wr_data[2:0] != 3'd0 && off0 == OFF) begin
        m_armed = 1; m_scale = int'(wr_data[2:0]); m_el = 0;  // R3
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 armed", int'(armed_o), int'(m_armed));
      chk("R4 scale", int'(scale_o), m_scale);
      chk("R8 early_err", int'(early_err_o), int'(m_err));
      chk("R5 expire", int'(expire_o), int'(m_exp));
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit mt, input bit ut);
    wr_en = w; wr_data = d; ms_tick = mt; us_tick = ut;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; ms_tick = 1'b0; us_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(1_500_000ns);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 armed", int'(armed_o), 0);
    chk("R1 scale", int'(scale_o), 0);
    chk("R1 err", int'(early_err_o), 0);
    chk("R1 expire", int'(expire_o), 0);

    // R9 kick while disarmed is ignored
    step(1, 8'h80, 0, 0);
    chk("R9 err", int'(early_err_o), 0);
    chk("R9 armed", int'(armed_o), 0);
    step(1, 8'h00, 0, 0);

    // R3 arming before the disarm gap is rejected
    step(1, 8'h02, 0, 0);
    chk("R3 reject", int'(armed_o), 0);
    repeat (OFF) step(0, 8'h00, 0, 1);
    step(1, 8'h02, 0, 0);
    chk("R3 armed", int'(armed_o), 1);
    chk("R3 scale", int'(scale_o), 2);

    // R4 rescale while armed ignored
    step(1, 8'h05, 0, 0);
    chk("R4 scale", int'(scale_o), 2);

    // R7 kick at window edge accepted
    repeat (WIN) step(0, 8'h00, 1, 0);
    step(1, 8'h82, 0, 0);
    chk("R7 err", int'(early_err_o), 0);
    chk("R7 armed", int'(armed_o), 1);

    // R6 held kick bit is not a kick (would be early otherwise)
    step(1, 8'h82, 0, 0);
    chk("R6 err", int'(early_err_o), 0);
    chk("R6 armed", int'(armed_o), 1);
    step(1, 8'h02, 0, 0);

    // R5 timeout of code 2 = 16 ticks
    repeat (timeout_of(2) - 1) step(0, 8'h00, 1, 0);
    chk("R5 before", int'(expire_o), 0);
    chk("R5 armed before", int'(armed_o), 1);
    step(0, 8'h00, 1, 0);
    chk("R5 pulse", int'(expire_o), 1);
    chk("R5 disarmed", int'(armed_o), 0);
    chk("R5 scale", int'(scale_o), 0);
    step(0, 8'h00, 0, 0);
    chk("R5 one cycle", int'(expire_o), 0);

    // R10 kick together with the final tick wins
    repeat (OFF) step(0, 8'h00, 0, 1);
    step(1, 8'h01, 0, 0);
    repeat (timeout_of(1) - 1) step(0, 8'h00, 1, 0);
    step(1, 8'h81, 1, 0);
    chk("R10 expire", int'(expire_o), 0);
    chk("R10 armed", int'(armed_o), 1);
    step(0, 8'h00, 0, 0);
    chk("R10 expire late", int'(expire_o), 0);

    // R11 disarm with kick bit: no early fault
    step(1, 8'h01, 0, 0);
    step(1, 8'h80, 0, 0);
    chk("R11 armed", int'(armed_o), 0);
    chk("R11 expire", int'(expire_o), 0);
    chk("R11 err", int'(early_err_o), 0);
    chk("R2 scale", int'(scale_o), 0);

    // R8 early kick right after arming
    repeat (OFF) step(0, 8'h00, 0, 1);
    step(1, 8'h01, 0, 0);
    step(1, 8'h81, 0, 0);
    chk("R8 err", int'(early_err_o), 1);
    chk("R8 expire", int'(expire_o), 1);
    chk("R8 armed", int'(armed_o), 0);
    repeat (5) step(0, 8'h00, 1, 1);
    chk("R8 sticky", int'(early_err_o), 1);

    // random phases: dense then sparse writes
    for (int i = 0; i < 6000; i++) begin
      int dens;
      dens = (i < 3000) ? 6 : 40;
      step(($urandom % dens) == 0, 8'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule